// File: doc/BRIEF.md
# Byte-Wide Memory Write-Protect Command Sequencer

This block sits on the write-strobe path of a parallel byte-wide EEPROM. It watches every bus write: a write counts when the write-enable rises while chip-enable is low. Exact address/data command sequences decide whether a write may reach the array. A three-step unlock opens a short page-load window. The bytes loaded in that window are committed and then protection arms itself. A six-step command removes protection. With protection off, ordinary writes pass straight through. With protection on, they are dropped without any trace.

A commit starts a fixed busy period, counted in clock cycles, and the bus is deaf until it ends. The protect bit models a nonvolatile cell. It starts at a factory default, and a power-on reset leaves it alone. That reset only clears the tracker, the load window and the busy state.

Top module: `sdp_guard`

## Requirements
- R1: In protected mode, the writes 0xAA at 0x5555, 0x55 at 0x2AAA and 0xA0 at 0x5555, in that order, open a load window. While the window is open, every write pulses `arr_we` for one cycle with that write's address and data. None of the three command writes pulses `arr_we`.
- R2: In protected mode, a write that is not part of a command sequence does not pulse `arr_we` and does not raise `busy`.
- R3: In unprotected mode, a write that is not part of a command sequence pulses `arr_we` with its address and data. It also raises `busy` for exactly TWC_CYC cycles.
- R4: A write that arrives while `busy` is high is ignored. It gives no `arr_we` pulse and does not stretch the busy period.
- R5: Once at least one byte is loaded, a window with no write for TBLC_CYC cycles closes. `busy` then rises for TWC_CYC cycles, and `prot` is 1 when `busy` falls.
- R6: The PAGE_BYTES-th byte in one window closes the window and raises `busy` in the same cycle. After that busy period the block is protected.
- R7: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA and 0x20@0x5555, in that order, raise `busy` for TWC_CYC cycles. `prot` is 0 afterwards. None of these six writes pulses `arr_we`.
- R8: A write that does not match the expected step abandons the sequence. That same write is then tested as a first step (0xAA@0x5555), so a new sequence can start on it at once. A sequence that was abandoned does not unlock.
- R9: Only address bits [14:0] are compared with the command addresses. A write-enable rise while chip-enable is high is not a write.
- R10: `prot` starts at PROT_DEFAULT (1) and keeps its value through `por_n`. `por_n` clears a partly entered command sequence.
- R11: A window that times out with no byte loaded leaves `prot` unchanged and does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Power-on reset, active low; keeps the protect bit |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken on its rise |
| addr | input | ADDR_W | Bus address |
| din | input | 8 | Bus data |
| arr_we | output | 1 | One-cycle write strobe to the array |
| arr_addr | output | ADDR_W | Address for the array write |
| arr_data | output | 8 | Data for the array write |
| busy | output | 1 | Internal write cycle in progress |
| prot | output | 1 | Protect bit (1 = protected) |

## Verification
The bench gives the unlock command addresses with bit 15 set. A design that compared the full address would never unlock and would drop the data. It measures the window timeout and the busy length cycle by cycle, so an off-by-one in either timer shows up as a wrong count. It sends a doubled 0xAA step, which has to restart the sequence on itself. It also sends a sequence broken by a stray write, which must leave the following bytes blocked. A tracker that skipped the re-test would miss the first case, and one that ignored the break would write the bytes. Finally, it issues a reset between the second and third unlock steps, and writes sent during a busy period. A design that kept tracker state across reset, or one that listened while busy, would let a byte through.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

   localparam int CMP_W = 15;

   localparam logic [CMP_W-1:0] CMD_ADR_HI = 15'h5555;
   localparam logic [CMP_W-1:0] CMD_ADR_LO = 15'h2AAA;

   localparam logic [7:0] CMD_KEY1  = 8'hAA;
   localparam logic [7:0] CMD_KEY2  = 8'h55;
   localparam logic [7:0] CMD_OPEN  = 8'hA0;
   localparam logic [7:0] CMD_ERASE = 8'h80;
   localparam logic [7:0] CMD_CLEAR = 8'h20;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_K1,
      SQ_K2,
      SQ_X80,
      SQ_X80K1,
      SQ_X80K2
   } seq_state_t;

endpackage

// File: rtl/sdp_wr_detect.sv
module sdp_wr_detect #(
   parameter int ADDR_W      = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   output logic              wr_evt,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data
);

   logic              ce_s, we_s;
   logic [ADDR_W-1:0] addr_s;
   logic [7:0]        data_s;
   logic              we_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign ce_s   = ce_n;
         assign we_s   = we_n;
         assign addr_s = addr;
         assign data_s = din;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] ce_sh, we_sh;
         logic [ADDR_W-1:0]      addr_sh [SYNC_STAGES];
         logic [7:0]             data_sh [SYNC_STAGES];
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               ce_sh <= '1;
               we_sh <= '1;
               for (int i = 0; i < SYNC_STAGES; i++) begin
                  addr_sh[i] <= '0;
                  data_sh[i] <= '0;
               end
            end else begin
               ce_sh[0]   <= ce_n;
               we_sh[0]   <= we_n;
               addr_sh[0] <= addr;
               data_sh[0] <= din;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  ce_sh[i]   <= ce_sh[i-1];
                  we_sh[i]   <= we_sh[i-1];
                  addr_sh[i] <= addr_sh[i-1];
                  data_sh[i] <= data_sh[i-1];
               end
            end
         end
         assign ce_s   = ce_sh[SYNC_STAGES-1];
         assign we_s   = we_sh[SYNC_STAGES-1];
         assign addr_s = addr_sh[SYNC_STAGES-1];
         assign data_s = data_sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) we_prev <= 1'b1;
      else        we_prev <= we_s;
   end

   assign wr_evt  = !we_prev && we_s && !ce_s;
   assign wr_addr = addr_s;
   assign wr_data = data_s;

endmodule

// File: rtl/sdp_cyc_timer.sv
module sdp_cyc_timer #(
   parameter int CYC = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic start,
   input  logic stop,
   output logic active,
   output logic done
);

   localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (stop) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (start) begin
         active <= 1'b1;
         cnt    <= CW'(CYC - 1);
      end else if (active) begin
         if (cnt == '0) active <= 1'b0;
         else           cnt    <= cnt - 1'b1;
      end
   end

   assign done = active && (cnt == '0);

endmodule

// File: rtl/sdp_cmd_seq.sv
module sdp_cmd_seq
   import sdp_pkg::*;
(
   input  logic             clk,
   input  logic             por_n,
   input  logic             wr,
   input  logic [CMP_W-1:0] a,
   input  logic [7:0]       d,
   output logic             consumed,
   output logic             unlock_hit,
   output logic             disable_hit
);

   seq_state_t st, nxt;
   logic hit_k1, hit_k2, hit_open, hit_erase, hit_clear;

   assign hit_k1    = (a == CMD_ADR_HI) && (d == CMD_KEY1);
   assign hit_k2    = (a == CMD_ADR_LO) && (d == CMD_KEY2);
   assign hit_open  = (a == CMD_ADR_HI) && (d == CMD_OPEN);
   assign hit_erase = (a == CMD_ADR_HI) && (d == CMD_ERASE);
   assign hit_clear = (a == CMD_ADR_HI) && (d == CMD_CLEAR);

   always_comb begin
      nxt         = st;
      consumed    = 1'b0;
      unlock_hit  = 1'b0;
      disable_hit = 1'b0;
      if (wr) begin
         unique case (st)
            SQ_K1:    if (hit_k2) begin nxt = SQ_K2; consumed = 1'b1; end
            SQ_K2: begin
               if (hit_open) begin
                  nxt = SQ_IDLE; consumed = 1'b1; unlock_hit = 1'b1;
               end else if (hit_erase) begin
                  nxt = SQ_X80; consumed = 1'b1;
               end
            end
            SQ_X80:   if (hit_k1) begin nxt = SQ_X80K1; consumed = 1'b1; end
            SQ_X80K1: if (hit_k2) begin nxt = SQ_X80K2; consumed = 1'b1; end
            SQ_X80K2: if (hit_clear) begin
               nxt = SQ_IDLE; consumed = 1'b1; disable_hit = 1'b1;
            end
            default: ;
         endcase
         // a write that breaks the sequence is re-tested as a first step
         if (!consumed) begin
            nxt      = hit_k1 ? SQ_K1 : SQ_IDLE;
            consumed = hit_k1;
         end
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) st <= SQ_IDLE;
      else        st <= nxt;
   end

endmodule

// File: rtl/sdp_guard.sv
module sdp_guard
   import sdp_pkg::*;
#(
   parameter int   ADDR_W       = 16,
   parameter int   TWC_CYC      = 16,
   parameter int   TBLC_CYC     = 8,
   parameter int   PAGE_BYTES   = 4,
   parameter int   SYNC_STAGES  = 0,
   parameter logic PROT_DEFAULT = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [7:0]        arr_data,
   output logic              busy,
   output logic              prot
);

   localparam int CNT_W = $clog2(PAGE_BYTES + 1);

   initial begin
      if (ADDR_W < CMP_W)   $error("ADDR_W must cover the compared address bits");
      if (TWC_CYC < 1)      $error("TWC_CYC must be at least 1");
      if (TBLC_CYC < 2)     $error("TBLC_CYC must be at least 2");
      if (PAGE_BYTES < 1)   $error("PAGE_BYTES must be at least 1");
      if (SYNC_STAGES < 0)  $error("SYNC_STAGES must not be negative");
   end

   logic              wr_evt;
   logic [ADDR_W-1:0] wr_addr;
   logic [7:0]        wr_data;
   logic              consumed, unlock_hit, disable_hit;
   logic              win_open, win_done, busy_done;
   logic              wr_ok, data_wr, seq_wr, fill_last, plain_wr, win_expire;
   logic              win_start, busy_start, arm_now;
   logic [CNT_W-1:0]  byte_cnt;
   logic              pend_set, pend_clr;
   logic              prot_q = PROT_DEFAULT;

   sdp_wr_detect #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk(clk), .por_n(por_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
      .din(din), .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   assign wr_ok   = wr_evt && !busy;
   assign data_wr = wr_ok && win_open;
   assign seq_wr  = wr_ok && !win_open;

   sdp_cmd_seq u_seq (
      .clk(clk), .por_n(por_n), .wr(seq_wr), .a(wr_addr[CMP_W-1:0]),
      .d(wr_data), .consumed(consumed), .unlock_hit(unlock_hit),
      .disable_hit(disable_hit)
   );

   assign fill_last  = data_wr && (byte_cnt == CNT_W'(PAGE_BYTES - 1));
   assign plain_wr   = seq_wr && !consumed && !prot_q;
   assign win_expire = win_done && !data_wr;
   assign arm_now    = fill_last || (win_expire && (byte_cnt != '0));
   assign win_start  = unlock_hit || (data_wr && !fill_last);
   assign busy_start = plain_wr || disable_hit || arm_now;

   sdp_cyc_timer #(.CYC(TBLC_CYC)) u_win (
      .clk(clk), .por_n(por_n), .start(win_start), .stop(fill_last),
      .active(win_open), .done(win_done)
   );

   sdp_cyc_timer #(.CYC(TWC_CYC)) u_wc (
      .clk(clk), .por_n(por_n), .start(busy_start), .stop(1'b0),
      .active(busy), .done(busy_done)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         byte_cnt <= '0;
         pend_set <= 1'b0;
         pend_clr <= 1'b0;
         arr_we   <= 1'b0;
         arr_addr <= '0;
         arr_data <= '0;
      end else begin
         arr_we <= data_wr || plain_wr;
         if (data_wr || plain_wr) begin
            arr_addr <= wr_addr;
            arr_data <= wr_data;
         end
         if (unlock_hit)   byte_cnt <= '0;
         else if (data_wr) byte_cnt <= byte_cnt + 1'b1;
         if (busy_done) begin
            pend_set <= 1'b0;
            pend_clr <= 1'b0;
         end else begin
            if (arm_now)     pend_set <= 1'b1;
            if (disable_hit) pend_clr <= 1'b1;
         end
      end
   end

   // nonvolatile cell: no reset term, only a commit changes it
   always_ff @(posedge clk) begin
      if (busy_done) begin
         if (pend_set)      prot_q <= 1'b1;
         else if (pend_clr) prot_q <= 1'b0;
      end
   end

   assign prot = prot_q;

endmodule

// File: rtl/sdp_guard_chk.sv
module sdp_guard_chk #(
   parameter int TWC_CYC = 16
) (
   input logic clk,
   input logic por_n,
   input logic arr_we,
   input logic busy,
   input logic prot,
   input logic win_open
);

   int unsigned run_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)    run_q <= 0;
      else if (busy) run_q <= run_q + 1;
      else           run_q <= 0;
   end

   p_strobe_single_r1: assert property (@(posedge clk) disable iff (!por_n)
      arr_we |=> !arr_we);

   p_gate_r2: assert property (@(posedge clk) disable iff (!por_n)
      arr_we |-> (!prot || $past(win_open)));

   p_busy_max_r3: assert property (@(posedge clk) disable iff (!por_n)
      busy |-> (run_q < TWC_CYC));

   p_busy_len_r3: assert property (@(posedge clk) disable iff (!por_n)
      $fell(busy) |-> (run_q == TWC_CYC));

   p_deaf_busy_r4: assert property (@(posedge clk) disable iff (!por_n)
      (busy && $past(busy)) |-> !arr_we);

   p_prot_commit_r5: assert property (@(posedge clk) disable iff (!por_n)
      !$stable(prot) |-> $fell(busy));

endmodule

bind sdp_guard sdp_guard_chk #(.TWC_CYC(TWC_CYC)) u_chk (
   .clk(clk), .por_n(por_n), .arr_we(arr_we), .busy(busy), .prot(prot),
   .win_open(win_open)
);

// File: tb/sdp_guard_bench.sv
`timescale 1ns/1ps
module sdp_guard_bench;

   localparam int ADDR_W = 16;
   localparam int TWC    = 16;
   localparam int TBLC   = 8;
   localparam int PAGE   = 4;

   logic              clk = 1'b0;
   logic              por_n = 1'b0;
   logic              ce_n = 1'b1;
   logic              we_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0]        din = '0;
   logic              arr_we, busy, prot;
   logic [ADDR_W-1:0] arr_addr;
   logic [7:0]        arr_data;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   sdp_guard #(
      .ADDR_W(ADDR_W), .TWC_CYC(TWC), .TBLC_CYC(TBLC), .PAGE_BYTES(PAGE)
   ) u_sdp_guard (
      .clk(clk), .por_n(por_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
      .din(din), .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data),
      .busy(busy), .prot(prot)
   );

   function automatic logic [7:0] safe_data(input logic [7:0] r);
      return (r == 8'hAA) ? 8'h3C : r;
   endfunction

   function automatic logic [15:0] safe_addr(input logic [15:0] r);
      return ((r[14:0] == 15'h5555) || (r[14:0] == 15'h2AAA)) ? (r ^ 16'h0001) : r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input logic cen = 1'b0);
      @(negedge clk); addr = a; din = d; ce_n = cen; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_busy(input string req, input int exp_len);
      int n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk(req, n, exp_len);
   endtask

   task automatic unlock(input string req, input logic [15:0] hi = 16'h5555,
                         input logic [15:0] lo = 16'h2AAA);
      bus_wr(hi, 8'hAA); chk(req, arr_we, 0);
      bus_wr(lo, 8'h55); chk(req, arr_we, 0);
      bus_wr(hi, 8'hA0); chk(req, arr_we, 0);
   endtask

   task automatic do_reset();
      @(negedge clk); por_n = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL all: watchdog actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      int n;
      logic [15:0] a;
      logic [7:0]  d;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 default prot", prot, 1);
      chk("R10 busy idle", busy, 0);
      chk("R10 no strobe", arr_we, 0);

      // R2 random writes while protected
      for (int i = 0; i < 20; i++) begin
         a = safe_addr(16'($urandom)); d = safe_data(8'($urandom));
         bus_wr(a, d);
         chk("R2 dropped strobe", arr_we, 0);
         chk("R2 dropped busy", busy, 0);
      end

      // R1 + R9: unlock via addresses with bit 15 set, two bytes
      unlock("R9 cmd strobe", 16'hD555, 16'hAAAA);
      bus_wr(16'h1234, 8'h5A);
      chk("R1 byte0 strobe", arr_we, 1);
      chk("R1 byte0 addr", arr_addr, 16'h1234);
      chk("R1 byte0 data", arr_data, 8'h5A);
      bus_wr(16'h1235, 8'hA5);
      chk("R1 byte1 strobe", arr_we, 1);
      chk("R1 byte1 data", arr_data, 8'hA5);
      // R5 timeout measured in idle cycles, then commit
      n = 0;
      while (!busy && n < 100) begin @(negedge clk); n++; end
      chk("R5 window timeout", n, TBLC);
      wait_busy("R5 commit length", TWC);
      chk("R5 re-armed", prot, 1);

      // R6 page full
      unlock("R6 cmd strobe");
      for (int i = 0; i < PAGE; i++) begin
         bus_wr(16'h0100 + 16'(i), 8'(i + 1));
         chk("R6 page strobe", arr_we, 1);
      end
      chk("R6 busy at full page", busy, 1);
      wait_busy("R6 commit length", TWC);
      chk("R6 protected", prot, 1);
      bus_wr(16'h0200, 8'h77);
      chk("R6 after page dropped", arr_we, 0);

      // R8 doubled first step restarts
      bus_wr(16'h5555, 8'hAA);
      bus_wr(16'h5555, 8'hAA);
      bus_wr(16'h2AAA, 8'h55);
      bus_wr(16'h5555, 8'hA0);
      bus_wr(16'h0300, 8'h11);
      chk("R8 restart unlock", arr_we, 1);
      n = 0;
      while (!busy && n < 100) begin @(negedge clk); n++; end
      wait_busy("R8 commit", TWC);
      // R8 broken sequence stays locked
      bus_wr(16'h5555, 8'hAA);
      bus_wr(16'h1234, 8'h11);
      bus_wr(16'h2AAA, 8'h55);
      bus_wr(16'h5555, 8'hA0);
      bus_wr(16'h0301, 8'h22);
      chk("R8 broken seq blocked", arr_we, 0);
      chk("R8 broken seq no busy", busy, 0);

      // R7 disable
      bus_wr(16'h5555, 8'hAA); chk("R7 step strobe", arr_we, 0);
      bus_wr(16'h2AAA, 8'h55); chk("R7 step strobe", arr_we, 0);
      bus_wr(16'h5555, 8'h80); chk("R7 step strobe", arr_we, 0);
      bus_wr(16'h5555, 8'hAA); chk("R7 step strobe", arr_we, 0);
      bus_wr(16'h2AAA, 8'h55); chk("R7 step strobe", arr_we, 0);
      bus_wr(16'h5555, 8'h20); chk("R7 step strobe", arr_we, 0);
      wait_busy("R7 disable length", TWC);
      chk("R7 unprotected", prot, 0);

      // R3 random unprotected writes
      for (int i = 0; i < 6; i++) begin
         a = safe_addr(16'($urandom)); d = safe_data(8'($urandom));
         bus_wr(a, d);
         chk("R3 strobe", arr_we, 1);
         chk("R3 addr", arr_addr, a);
         chk("R3 data", arr_data, d);
         wait_busy("R3 busy length", TWC);
      end

      // R4 write during busy
      bus_wr(16'h0400, 8'h44);
      chk("R4 first strobe", arr_we, 1);
      bus_wr(16'h0401, 8'h45);
      chk("R4 ignored strobe", arr_we, 0);
      wait_busy("R4 busy not stretched", TWC - 3);

      // R9 write with chip-enable high
      bus_wr(16'h0500, 8'h55, 1'b1);
      chk("R9 ce high strobe", arr_we, 0);
      chk("R9 ce high busy", busy, 0);

      // R11 unlock without bytes
      unlock("R11 cmd strobe");
      repeat (TBLC + 4) @(negedge clk);
      chk("R11 no busy", busy, 0);
      chk("R11 prot kept", prot, 0);
      bus_wr(16'h0600, 8'h66);
      chk("R11 plain passes", arr_we, 1);
      wait_busy("R11 busy", TWC);

      // R10 protect through reset, tracker cleared
      unlock("R10 cmd strobe");
      bus_wr(16'h0700, 8'h70);
      n = 0;
      while (!busy && n < 100) begin @(negedge clk); n++; end
      wait_busy("R10 commit", TWC);
      chk("R10 armed", prot, 1);
      do_reset();
      chk("R10 prot kept", prot, 1);
      bus_wr(16'h5555, 8'hAA);
      bus_wr(16'h2AAA, 8'h55);
      do_reset();
      bus_wr(16'h5555, 8'hA0);
      bus_wr(16'h0701, 8'h71);
      chk("R10 tracker cleared", arr_we, 0);
      chk("R10 prot still", prot, 1);

      summary();
      $finish;
   end

endmodule